// File: doc/BRIEF.md
# PCM Codec Serial Time-Slot Port

This block is the digital serial side of a telephony PCM codec. Each frame it moves one companded sample in each direction, W bits wide (8 by default). On the transmit side the encoder writes its result into a holding register. The byte waits there until the next transmit frame sync, and is then shifted out MSB first on a data pin with its own output enable. The bit clock times the shifting, and the pin is released between slots. On the receive side, a receive frame sync opens a slot. The following W falling edges of the receive bit clock shift in the serial data, and the finished byte goes to the decoder with a one-cycle strobe.

All serial pins are asynchronous to the fast system clock. They pass through multi-flop synchronizers, and their edges are detected in the system-clock domain. In synchronous mode the transmit bit clock times both directions and the receive bit clock is ignored. In asynchronous mode each direction uses its own bit clock. A frame sync may be a short pulse or a long pulse.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, dout_oe is 0, rx_valid is 0, tx_underrun is 0, and the holding register is zero.
- R2: dout_oe goes high only once the transmit frame sync and the transmit bit clock are both high, whichever of the two rises later. While the frame sync is high and the bit clock is still low, the pin stays released.
- R3: The bit driven first is the MSB of the frame's code. Each of the next W-1 rising edges of the transmit bit clock moves dout to the next lower bit, and dout changes at no other time while enabled.
- R4: dout_oe drops at whichever comes later: the bit-clock falling edge after the W-th rising edge, or the transmit frame sync going low. With a long frame sync the pin stays driven past the last bit until the sync falls.
- R5: A code loaded with enc_load during a slot does not alter the bits being sent. It is sent in the next slot.
- R6: A frame sync rise accepted with no enc_load since the previous accepted rise sets tx_underrun to 1, and the previous code is sent again. An accepted rise with a fresh code sets tx_underrun to 0.
- R7: After a receive frame sync rise, din is sampled on each of the next W falling edges of the receive bit clock, first bit as MSB. rx_byte then holds the byte, and rx_valid is high for exactly one cycle.
- R8: With sync_mode at 1, reception is timed by bclk_tx falling edges, and bclk_rx has no effect.
- R9: With sync_mode at 0, reception is timed by bclk_rx falling edges, independently of bclk_tx.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low reset |
| sync_mode | input | 1 | 1: bclk_tx times both directions; 0: separate bit clocks |
| bclk_tx | input | 1 | Transmit bit clock |
| bclk_rx | input | 1 | Receive bit clock (asynchronous mode only) |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| din | input | 1 | Serial receive data |
| enc_code | input | W | Code from the encoder |
| enc_load | input | 1 | Writes enc_code into the holding register |
| dout | output | 1 | Serial transmit data, valid while dout_oe is high |
| dout_oe | output | 1 | Transmit driver enable; low means high impedance |
| rx_byte | output | W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |
| tx_underrun | output | 1 | Slot started without a fresh code |

## Verification
The hardest case to reach is the end of a slot. There the pin must be released at the later of two events, and those events come from different inputs. The stimulus covers both orders. It holds the frame sync high past the last bit and checks that the pin stays driven. It also drops the frame sync after the first bit and checks that the pin is released right after the last falling edge. In asynchronous mode the receive clock runs in antiphase to the transmit clock, so sampling on the wrong clock would pick up the neighbouring bit. Loads in the middle of a slot, and slots with no load at all, are mixed in at random.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_mode,
  input  logic         bclk_tx,
  input  logic         bclk_rx,
  input  logic         fs_tx,
  input  logic         fs_rx,
  input  logic         din,
  input  logic [W-1:0] enc_code,
  input  logic         enc_load,
  output logic         dout,
  output logic         dout_oe,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid,
  output logic         tx_underrun
);
  localparam int CW = $clog2(W + 1);

  logic [SYNC:0][4:0] sy;
  logic [4:0] cur, prv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '0;
    else        sy <= {sy[SYNC-1:0], {din, fs_rx, fs_tx, bclk_rx, bclk_tx}};

  assign cur = sy[SYNC-1];
  assign prv = sy[SYNC];

  logic bt, ft, fr, dd, rclk, prclk;
  logic bt_rise, bt_fall, ft_rise, fr_rise, r_fall;
  assign bt      = cur[0];
  assign ft      = cur[2];
  assign fr      = cur[3];
  assign dd      = cur[4];
  assign rclk    = sync_mode ? cur[0] : cur[1];
  assign prclk   = sync_mode ? prv[0] : prv[1];
  assign bt_rise = bt & ~prv[0];
  assign bt_fall = ~bt & prv[0];
  assign ft_rise = ft & ~prv[2];
  assign fr_rise = fr & ~prv[3];
  assign r_fall  = ~rclk & prclk;

  logic [W-1:0]  hold_q, shf_q;
  logic          fresh_q, armed, tail;
  logic [CW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0; shf_q <= '0; fresh_q <= 1'b0; armed <= 1'b0;
      tail <= 1'b0; tcnt <= '0; dout_oe <= 1'b0; tx_underrun <= 1'b0;
    end else begin
      if (enc_load) begin
        hold_q  <= enc_code;
        fresh_q <= 1'b1;
      end
      if (ft_rise && !armed && !dout_oe && !tail) begin
        shf_q       <= hold_q;
        armed       <= 1'b1;
        tx_underrun <= ~fresh_q;
        if (!enc_load) fresh_q <= 1'b0;
      end else if (armed && ft && bt) begin
        armed   <= 1'b0;
        dout_oe <= 1'b1;
        tcnt    <= CW'(1);
      end else if (dout_oe) begin
        if (bt_rise && tcnt < CW'(W)) begin
          shf_q <= shf_q << 1;
          tcnt  <= tcnt + CW'(1);
        end
        if (bt_fall && tcnt == CW'(W)) tail <= 1'b1;
        if (tail && !ft) begin
          dout_oe <= 1'b0;
          tail    <= 1'b0;
        end
      end
    end
  end

  assign dout = dout_oe & shf_q[W-1];

  logic          rbusy;
  logic [CW-1:0] rcnt;
  logic [W-1:0]  rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbusy <= 1'b0; rcnt <= '0; rsh <= '0; rx_byte <= '0; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fr_rise && !rbusy) begin
        rbusy <= 1'b1;
        rcnt  <= '0;
      end else if (rbusy && r_fall) begin
        rsh <= {rsh[W-2:0], dd};
        if (rcnt == CW'(W - 1)) begin
          rbusy    <= 1'b0;
          rx_byte  <= {rsh[W-2:0], dd};
          rx_valid <= 1'b1;
        end else begin
          rcnt <= rcnt + CW'(1);
        end
      end
    end
  end
endmodule

module pcm_slot_port_chk (
  input logic clk,
  input logic rst_n,
  input logic dout,
  input logic dout_oe,
  input logic rx_valid,
  input logic rx_busy,
  input logic fs_tx_s,
  input logic bclk_tx_s,
  input logic bt_rise
);
  assert_oe_needs_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(fs_tx_s && bclk_tx_s));

  assert_shift_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe) && (dout != $past(dout))) |-> $past(bt_rise));

  assert_release_after_fs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe) |-> $past(!fs_tx_s));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_valid_ends_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rx_busy);
endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dout(dout), .dout_oe(dout_oe), .rx_valid(rx_valid),
  .rx_busy(rbusy), .fs_tx_s(ft), .bclk_tx_s(bt), .bt_rise(bt_rise)
);

// File: tb/pcm_slot_port_tb_top.sv
module pcm_slot_port_tb_top;
  localparam int W = 8;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n, sync_mode, bclk_tx, bclk_rx, fs_tx, fs_rx, din, enc_load;
  logic [W-1:0] enc_code, rx_byte;
  logic dout, dout_oe, rx_valid, tx_underrun;

  int checks = 0, errors = 0, rx_cnt = 0;
  logic [W-1:0] rx_last = '0;
  logic [W-1:0] hold_m = '0;
  bit fresh_m = 0;

  always #2 clk = ~clk;

  pcm_slot_port #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .bclk_tx(bclk_tx), .bclk_rx(bclk_rx),
    .fs_tx(fs_tx), .fs_rx(fs_rx), .din(din), .enc_code(enc_code), .enc_load(enc_load),
    .dout(dout), .dout_oe(dout_oe), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .tx_underrun(tx_underrun)
  );

  always @(posedge clk) if (rx_valid) begin rx_cnt++; rx_last = rx_byte; end

  function automatic logic exp_bit(input logic [W-1:0] code, input int i);
    return code[W-1-i];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n * H) @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] code);
    enc_code = code; enc_load = 1'b1;
    @(negedge clk);
    enc_load = 1'b0; hold_m = code; fresh_m = 1;
  endtask

  task automatic frame(input bit sm, input bit longfs, input bit latefs, input bit midload,
                       input logic [W-1:0] rxb, input logic [W-1:0] newc);
    logic [W-1:0] exp_c = hold_m;
    bit exp_u = !fresh_m;
    int c0 = rx_cnt;
    fresh_m = 0;
    sync_mode = sm; bclk_tx = 0; bclk_rx = sm ? 1'b0 : 1'b1;
    din = sm ? 1'b0 : rxb[W-1];
    wait_h(1);
    if (!latefs) begin
      fs_tx = 1; fs_rx = 1;
      wait_h(1);
      chk(dout_oe == 1'b0, "R2 released before bit clock rise", dout_oe, 0);
    end
    for (int i = 0; i < W; i++) begin
      if (sm) din = rxb[W-1-i];
      bclk_tx = 1; if (!sm) bclk_rx = 0;
      if (latefs && i == 0) begin
        repeat (H/2) @(negedge clk);
        chk(dout_oe == 1'b0, "R2 released before frame sync", dout_oe, 0);
        fs_tx = 1; fs_rx = 1;
        repeat (H - H/2) @(negedge clk);
      end else wait_h(1);
      chk(dout_oe == 1'b1, "R2 driver on in slot", dout_oe, 1);
      chk(dout == exp_bit(exp_c, i), midload ? "R5 bit under mid-slot load" : "R3 bit order",
          dout, exp_bit(exp_c, i));
      if (i == 0) chk(tx_underrun == exp_u, "R6 underrun flag", tx_underrun, exp_u);
      bclk_tx = 0;
      if (!sm) begin bclk_rx = 1; if (i < W-1) din = rxb[W-2-i]; end
      if (!longfs && i == 0) begin fs_tx = 0; fs_rx = 0; end
      if (midload && i == 3) begin
        load(newc);
        repeat (H - 1) @(negedge clk);
      end else wait_h(1);
    end
    if (longfs) begin
      chk(dout_oe == 1'b1, "R4 held by long frame sync", dout_oe, 1);
      fs_tx = 0; fs_rx = 0;
      wait_h(1);
      chk(dout_oe == 1'b0, "R4 release after sync falls", dout_oe, 0);
    end else begin
      chk(dout_oe == 1'b0, "R4 release after last fall", dout_oe, 0);
    end
    wait_h(2);
    chk(rx_cnt == c0 + 1, "R7 one strobe per slot", rx_cnt - c0, 1);
    chk(rx_last == rxb, sm ? "R8 sync-mode byte" : "R9 async-mode byte", rx_last, rxb);
    bclk_rx = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0DE5));
    rst_n = 0; sync_mode = 1; bclk_tx = 0; bclk_rx = 0; fs_tx = 0; fs_rx = 0;
    din = 0; enc_load = 0; enc_code = '0;
    repeat (5) @(negedge clk);
    chk(dout_oe == 1'b0, "R1 oe at reset", dout_oe, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid at reset", rx_valid, 0);
    chk(tx_underrun == 1'b0, "R1 underrun at reset", tx_underrun, 0);
    rst_n = 1;
    wait_h(1);
    frame(1, 1, 0, 0, 8'h11, 8'h00);
    load(8'hA5);
    frame(1, 1, 0, 0, 8'h3C, 8'h00);
    frame(1, 0, 1, 0, 8'hC3, 8'h00);
    load(8'h5A);
    frame(0, 1, 0, 0, 8'h96, 8'h00);
    load(8'h81);
    frame(0, 0, 0, 1, 8'h7E, 8'h42);
    frame(1, 1, 0, 0, 8'h01, 8'h00);
    for (int k = 0; k < 20; k++) begin
      bit sm = $urandom % 2;
      if ($urandom % 4 != 0) load(W'($urandom));
      frame(sm, bit'($urandom % 2), sm & bit'($urandom % 2), ($urandom % 5) == 0,
            W'($urandom), W'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule